// File: doc/BRIEF.md
# Dual-Bank Doubleword Load Path with Late Carry Select

This block is the read datapath of a direct-mapped data store indexed by a register-plus-offset address. The store holds doublewords in two half-size banks: one bank for even doubleword indices and one for odd. Each bank has its own decoder. The decoder takes the index fields of the base register and the offset directly, with no add in front of it. Each row compares the two fields against its own row number in carry-save form. A row fires when the index sum equals its number or that number minus one.

Both banks are read in the same access. The carry out of the three low address bits is known only late. It then picks which of the two fetched doublewords is the real target. After the pick, the block moves the addressed bytes down to bit 0 for a 1-, 2-, 4- or 8-byte load. It then fills the upper bits with sign or with zeros. The full virtual address sum is still formed in parallel and exported for the other pipeline units.

The block has one byte-enabled write port, addressed by a full doubleword index. The load result appears registered one cycle after the request.

Top module: `sam_dual_bank_load`

## Requirements
- R1: `vaddr` always equals `base_addr + offset` modulo 2^ADDR_W, combinationally.
- R2: When `req_valid` is high, the next cycle has `rsp_valid` high. Its data comes from the doubleword at index `vaddr[IDX_W+2:3]`. Address bits above that field do not affect which doubleword is read. When `req_valid` is low, the next cycle has `rsp_valid` low.
- R3: A doubleword with index bit 0 clear lives in the even bank, and one with bit 0 set lives in the odd bank. For every access, each bank's decoder raises exactly one word line.
- R4: The chosen bank is the odd bank exactly when the parity of the high-field sum `I = base_addr[IDX_W+2:3] + offset[IDX_W+2:3]` differs from the low carry out of `base_addr[2:0] + offset[2:0]`. The chosen row is the one holding index `I` or `I+1` accordingly.
- R5: The `size` encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Bytes are little-endian. The loaded value starts at byte `vaddr[2:0]` of the doubleword and is placed at bit 0 of `rsp_data`.
- R6: With `sign_ext` = 1, bits above the loaded width copy its top bit. With `sign_ext` = 0, they are zero.
- R7: An access whose `vaddr[2:0]` is not a multiple of the load size returns `rsp_misalign` = 1 and `rsp_data` = 0. Aligned accesses return `rsp_misalign` = 0.
- R8: A write with `wr_en` = 1 updates only the byte lanes of doubleword `wr_index` whose bit is set in `wr_be`. Lane n is bits [8n+7:8n]. No other doubleword and no other lane changes.
- R9: A read and a write to the same doubleword in the same cycle return the data from before the write. A later read sees the new data.
- R10: While reset is asserted (active low), and at the first sample after it is released, `rsp_valid`, `rsp_misalign` and `rsp_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request |
| base_addr | input | ADDR_W | Base register value |
| offset | input | ADDR_W | Address offset |
| size | input | 2 | Load width code (0..3 = 1, 2, 4, 8 bytes) |
| sign_ext | input | 1 | 1 = sign-extend, 0 = zero-extend |
| wr_en | input | 1 | Write strobe |
| wr_index | input | IDX_W | Doubleword index to write |
| wr_be | input | 8 | Byte lane enables |
| wr_data | input | 64 | Write data |
| vaddr | output | ADDR_W | Full virtual address sum |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_data | output | 64 | Steered and extended load result |
| rsp_misalign | output | 1 | Alignment error flag |

## Verification
The bench uses a small store of 32 doublewords. It sweeps the offset through every value of the low eight address bits, paired with a spread of base values that also carry high address bits. This hits every combination of high-field parity and low carry, so a wrong bank pick shows up as data from the neighbouring doubleword. The same sweep runs for all four sizes, with both sign and zero fill. Values are chosen so that top bits of both polarities occur, which separates steering errors from extension errors and aligned from misaligned offsets. Partial byte-enable writes and a collision between a read and a write to the same doubleword check lane isolation and old-data-on-collision.

// File: rtl/sam_pkg.sv
package sam_pkg;

  localparam int LANES  = 8;
  localparam int DATA_W = 8 * LANES;
  localparam int BOFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    LD_BYTE = 2'd0,
    LD_HALF = 2'd1,
    LD_WORD = 2'd2,
    LD_DBL  = 2'd3
  } ld_size_e;

  // Carry out of the byte-offset field sum.
  function automatic logic low_carry(input logic [BOFF_W-1:0] a,
                                     input logic [BOFF_W-1:0] b);
    logic [BOFF_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[BOFF_W];
  endfunction

  function automatic logic lane_aligned(input logic [BOFF_W-1:0] boff,
                                        input ld_size_e sz);
    case (sz)
      LD_BYTE: return 1'b1;
      LD_HALF: return ~boff[0];
      LD_WORD: return boff[1:0] == 2'b00;
      default: return boff == '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] steer_extend(input logic [DATA_W-1:0] dw,
                                                     input logic [BOFF_W-1:0] boff,
                                                     input ld_size_e sz,
                                                     input logic sgn);
    logic [DATA_W-1:0] sh;
    sh = dw >> {boff, 3'b000};
    case (sz)
      LD_BYTE: return {{(DATA_W-8){sgn & sh[7]}}, sh[7:0]};
      LD_HALF: return {{(DATA_W-16){sgn & sh[15]}}, sh[15:0]};
      LD_WORD: return {{(DATA_W-32){sgn & sh[31]}}, sh[31:0]};
      default: return sh;
    endcase
  endfunction

endpackage

// File: rtl/sam_fused_decoder.sv
module sam_fused_decoder #(
  parameter int IDX_W = 11,
  parameter bit ODD   = 1'b0
) (
  input  logic [IDX_W-1:0]          idx_r,
  input  logic [IDX_W-1:0]          idx_o,
  output logic [2**(IDX_W-1)-1:0]   wl
);
  localparam int ROWS = 2**(IDX_W-1);

  // Shared per-bit terms, bit k stored at k-1. Name xAB: A = row bit k, B = row bit k-1.
  logic [IDX_W-2:0] x00, x01, x10, x11;

  genvar k;
  generate
    for (k = 1; k < IDX_W; k++) begin : g_bit
      logic half_one, half_zero, cy_or, cy_and;
      assign half_one  = ~(idx_r[k] ^ idx_o[k]);  // sum bit with ~L_k = 1
      assign half_zero =  (idx_r[k] ^ idx_o[k]);  // sum bit with ~L_k = 0
      assign cy_or     = idx_r[k-1] | idx_o[k-1]; // carry with ~L_{k-1} = 1
      assign cy_and    = idx_r[k-1] & idx_o[k-1]; // carry with ~L_{k-1} = 0
      assign x00[k-1]  = half_one  ^ cy_or;
      assign x01[k-1]  = half_one  ^ cy_and;
      assign x10[k-1]  = half_zero ^ cy_or;
      assign x11[k-1]  = half_zero ^ cy_and;
    end
  endgenerate

  function automatic logic row_match(input logic [IDX_W-2:0] a00,
                                     input logic [IDX_W-2:0] a01,
                                     input logic [IDX_W-2:0] a10,
                                     input logic [IDX_W-2:0] a11,
                                     input logic [IDX_W-1:0] lrow);
    logic hit;
    hit = 1'b1;
    for (int b = 1; b < IDX_W; b++) begin
      case ({lrow[b], lrow[b-1]})
        2'b00:   hit = hit & a00[b-1];
        2'b01:   hit = hit & a01[b-1];
        2'b10:   hit = hit & a10[b-1];
        default: hit = hit & a11[b-1];
      endcase
    end
    return hit;
  endfunction

  genvar j;
  generate
    for (j = 0; j < ROWS; j++) begin : g_row
      localparam logic [IDX_W-1:0] LROW = IDX_W'(2 * j + int'(ODD));
      assign wl[j] = row_match(x00, x01, x10, x11, LROW);
    end
  endgenerate

endmodule

// File: rtl/sam_bank.sv
module sam_bank #(
  parameter int ROW_W = 10
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [ROW_W-1:0]            wr_row,
  input  logic [sam_pkg::LANES-1:0]   wr_be,
  input  logic [sam_pkg::DATA_W-1:0]  wr_data,
  input  logic [2**ROW_W-1:0]         wl,
  output logic [sam_pkg::DATA_W-1:0]  rd_data
);
  localparam int ROWS = 2**ROW_W;

  logic [sam_pkg::DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < sam_pkg::LANES; l++) begin
        if (wr_be[l]) mem[wr_row][8*l +: 8] <= wr_data[8*l +: 8];
      end
    end
  end

  // Word-line driven read: one-hot OR across the rows.
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wl[r]) rd_data = rd_data | mem[r];
    end
  end

endmodule

// File: rtl/sam_late_select.sv
module sam_late_select
  import sam_pkg::*;
(
  input  logic [DATA_W-1:0] even_dw,
  input  logic [DATA_W-1:0] odd_dw,
  input  logic              idx_lsb,
  input  logic              carry_lo,
  input  logic [BOFF_W-1:0] boff,
  input  ld_size_e          size,
  input  logic              sign_ext,
  output logic              tgt_odd,
  output logic              misalign,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] picked;

  assign tgt_odd  = idx_lsb ^ carry_lo;
  assign picked   = tgt_odd ? odd_dw : even_dw;
  assign misalign = ~lane_aligned(boff, size);
  assign result   = misalign ? '0 : steer_extend(picked, boff, size, sign_ext);

endmodule

// File: rtl/sam_dual_bank_load.sv
module sam_dual_bank_load
  import sam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] offset,
  input  logic [1:0]        size,
  input  logic              sign_ext,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [7:0]        wr_be,
  input  logic [63:0]       wr_data,
  output logic [ADDR_W-1:0] vaddr,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_misalign
);
  localparam int ROW_W = IDX_W - 1;
  localparam int ROWS  = 2**ROW_W;
  localparam int IDX_LO = BOFF_W;
  localparam int IDX_HI = BOFF_W + IDX_W - 1;

  // Named internal events for the checker.
  logic [IDX_W-1:0]  idx_r, idx_o, true_idx;
  logic              carry_lo, idx_lsb, tgt_odd, misalign;
  logic [ROWS-1:0]   wl_even, wl_odd;
  logic [ROWS-1:0]   wl_bank [2];
  logic [DATA_W-1:0] bank_rd [2];
  logic [DATA_W-1:0] result;

  // Full sum in parallel for other units.
  assign vaddr    = base_addr + offset;
  assign true_idx = vaddr[IDX_HI:IDX_LO];

  assign idx_r    = base_addr[IDX_HI:IDX_LO];
  assign idx_o    = offset[IDX_HI:IDX_LO];
  assign idx_lsb  = idx_r[0] ^ idx_o[0];
  assign carry_lo = low_carry(base_addr[BOFF_W-1:0], offset[BOFF_W-1:0]);

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      sam_fused_decoder #(.IDX_W(IDX_W), .ODD(b[0])) u_dec (
        .idx_r (idx_r),
        .idx_o (idx_o),
        .wl    (wl_bank[b])
      );
      sam_bank #(.ROW_W(ROW_W)) u_bank (
        .clk     (clk),
        .wr_en   (wr_en && (wr_index[0] == b[0])),
        .wr_row  (wr_index[IDX_W-1:1]),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .wl      (wl_bank[b]),
        .rd_data (bank_rd[b])
      );
    end
  endgenerate

  assign wl_even = wl_bank[0];
  assign wl_odd  = wl_bank[1];

  sam_late_select u_sel (
    .even_dw  (bank_rd[0]),
    .odd_dw   (bank_rd[1]),
    .idx_lsb  (idx_lsb),
    .carry_lo (carry_lo),
    .boff     (vaddr[BOFF_W-1:0]),
    .size     (ld_size_e'(size)),
    .sign_ext (sign_ext),
    .tgt_odd  (tgt_odd),
    .misalign (misalign),
    .result   (result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_misalign <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_data     <= result;
        rsp_misalign <= misalign;
      end
    end
  end

endmodule

// File: rtl/sam_dual_bank_load_chk.sv
module sam_dual_bank_load_chk #(
  parameter int IDX_W = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [IDX_W-1:0]         true_idx,
  input logic                     tgt_odd,
  input logic [2**(IDX_W-1)-1:0]  wl_even,
  input logic [2**(IDX_W-1)-1:0]  wl_odd,
  input logic                     rsp_valid,
  input logic                     rsp_misalign,
  input logic [63:0]              rsp_data
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2

  AST_EVEN_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(wl_even) == 1); // R3

  AST_ODD_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(wl_odd) == 1); // R3

  AST_PICK_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> tgt_odd == true_idx[0]); // R4

  AST_PICK_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (tgt_odd ? wl_odd[true_idx[IDX_W-1:1]]
                           : wl_even[true_idx[IDX_W-1:1]])); // R4

  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_misalign |-> rsp_data == 64'd0); // R7

endmodule

bind sam_dual_bank_load sam_dual_bank_load_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .true_idx     (true_idx),
  .tgt_odd      (tgt_odd),
  .wl_even      (wl_even),
  .wl_odd       (wl_odd),
  .rsp_valid    (rsp_valid),
  .rsp_misalign (rsp_misalign),
  .rsp_data     (rsp_data)
);

// File: tb/sam_dual_bank_load_tb_top.sv
module sam_dual_bank_load_tb_top;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 5;
  localparam int NDW    = 2**IDX_W;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] base_addr, offset;
  logic [1:0]        size;
  logic              sign_ext;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_index;
  logic [7:0]        wr_be;
  logic [63:0]       wr_data;
  logic [ADDR_W-1:0] vaddr;
  logic              rsp_valid;
  logic [63:0]       rsp_data;
  logic              rsp_misalign;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] ref_mem [NDW];

  always #(CLK_PERIOD/2) clk = ~clk;

  sam_dual_bank_load #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_addr(base_addr),
    .offset(offset), .size(size), .sign_ext(sign_ext), .wr_en(wr_en),
    .wr_index(wr_index), .wr_be(wr_be), .wr_data(wr_data), .vaddr(vaddr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_misalign(rsp_misalign)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [7:0] be, input logic [63:0] d);
    wr_en = 1; wr_index = IDX_W'(idx); wr_be = be; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    for (int l = 0; l < 8; l++) if (be[l]) ref_mem[idx][8*l +: 8] = d[8*l +: 8];
  endtask

  function automatic logic [63:0] expect_load(input logic [ADDR_W-1:0] a,
                                              input int sz, input bit sg,
                                              output bit mis);
    int idx, bo, n;
    logic [63:0] v;
    idx = int'(a[IDX_W+2:3]);
    bo  = int'(a[2:0]);
    n   = 1 << sz;
    mis = (bo % n) != 0;
    v = '0;
    if (mis) return v;
    for (int k = 0; k < n; k++) v[8*k +: 8] = ref_mem[idx][8*(bo+k) +: 8];
    if (sg && v[8*n-1]) for (int k = 8*n; k < 64; k++) v[k] = 1'b1;
    return v;
  endfunction

  // One load: drive at negedge, check at the following negedge.
  task automatic do_read(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] o,
                         input int sz, input bit sg, input string tag);
    logic [ADDR_W-1:0] full;
    logic [63:0] e;
    bit mis;
    full = b + o;
    e = expect_load(full, sz, sg, mis);
    req_valid = 1; base_addr = b; offset = o; size = 2'(sz); sign_ext = sg;
    #1;
    check(vaddr == full, "R1 vaddr", 64'(vaddr), 64'(full));
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_misalign == mis, "R7 misalign flag", 64'(rsp_misalign), 64'(mis));
    check(rsp_data == e, tag, rsp_data, e);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] oldv;
    rst_n = 0; req_valid = 0; base_addr = '0; offset = '0; size = '0; sign_ext = 0;
    wr_en = 0; wr_index = '0; wr_be = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R10: outputs cleared during reset
    check(rsp_valid == 0 && rsp_misalign == 0 && rsp_data == 0, "R10 reset outputs",
          rsp_data, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0 && rsp_data == 0, "R10 after release", rsp_data, 64'd0);

    // Fill every doubleword; even and odd banks (R3, R8 full lanes).
    for (int i = 0; i < NDW; i++)
      do_write(i, 8'hFF, (64'(i) * 64'h0123_4567_89AB_CDEF) ^ {i[0], 63'h5A5A_A5A5_0F0F_F0F0});
    for (int i = 0; i < NDW; i++)
      do_read(ADDR_W'(i * 8), '0, 3, 0, "R3 bank placement");

    // R2: idle cycle yields no response
    @(negedge clk);
    check(rsp_valid == 0, "R2 idle no rsp", 64'(rsp_valid), 64'd0);

    // R8: partial byte-enable write touches only enabled lanes of one doubleword
    do_write(6, 8'b1010_0101, 64'hDEAD_BEEF_CAFE_F00D);
    do_write(7, 8'b0001_1000, 64'h1122_3344_5566_7788);
    for (int i = 5; i < 9; i++)
      do_read(ADDR_W'(i * 8), '0, 3, 0, "R8 lane isolation");

    // R9: read and write to same doubleword in same cycle returns old data
    oldv = ref_mem[9];
    req_valid = 1; base_addr = ADDR_W'(9 * 8); offset = '0; size = 2'd3; sign_ext = 0;
    wr_en = 1; wr_index = IDX_W'(9); wr_be = 8'hFF; wr_data = 64'hFEED_0000_1234_ABCD;
    @(posedge clk); @(negedge clk);
    req_valid = 0; wr_en = 0;
    check(rsp_data == oldv, "R9 collision old data", rsp_data, oldv);
    ref_mem[9] = 64'hFEED_0000_1234_ABCD;
    do_read(ADDR_W'(9 * 8), '0, 3, 0, "R9 new data after write");

    // R4/R5/R6/R7 sweep: every low-8-bit offset against spread of bases with high bits
    for (int sz = 0; sz < 4; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int bi = 0; bi < 20; bi++)
          for (int o = 0; o < 256; o++)
            do_read(ADDR_W'(bi * 13 + (bi % 3) * 12'h500), ADDR_W'(o + (o % 5) * 12'h100),
                    sz, sg[0], sz == 3 ? "R4 late select" : (sg != 0 ? "R6 sign fill" : "R5 steering"));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule